// File: doc/BRIEF.md
# Line Allocation Counter Table Controller

The block tracks an allocation count for every hashed physical line of a line-granular memory. Each line has a 2-bit saturating counter and a stored virtual tag, which is the object reference together with the index inside that object. Requests arrive with a line index, already produced by an external hash, and the virtual tag of the requester. An access request is resolved from the counter alone whenever possible. The tag is compared only when several allocations have landed on the line, or when the count is no longer known.

The counter and the tag are read from two internal synchronous RAMs in the same cycle. The tag read therefore runs alongside the count read rather than after it. A mismatch produces a rehash request. The requester then hashes again and reissues the access to another line. The block counts consecutive rehash answers. Once the configured limit is reached, it answers with a miss fault instead. After reset, a sequential sweep clears every counter before the first request is taken.

Top module: `line_alloc_ctrl`

## Requirements
- R1: After reset release, `ready_o` stays low for exactly 2^LINE_W clock edges while every counter is written to zero. Requests presented during that time are ignored, and `rsp_valid_o` stays low.
- R2: Encodings used at the ports:
  - Operation codes: 00 access, 01 allocate, 10 deallocate; 11 behaves as access.
  - Count codes: 00 zero, 01 one, 10 many, 11 unknown.
  - Response codes: 0 direct, 1 invalid, 2 tag hit, 3 rehash, 4 miss fault, 5 updated.
  - `rsp_count_o` always carries the line's count before the request.
- R3: Allocate answers updated and moves the count as follows: zero to one, one to many, many to many, unknown to many. The stored tag is replaced only when the prior count was zero.
- R4: Deallocate answers updated and moves the count as follows: one to zero, many to unknown. Zero and unknown are left unchanged.
- R5: An access never changes the count. A zero count answers invalid. A count of one answers direct, whatever tag is presented.
- R6: An access to a line whose count is many or unknown answers tag hit when the presented tag equals the stored tag.
- R7: An access with count many or unknown and a tag mismatch is handled against a count of consecutive rehash answers:
  - If fewer than MAX_REHASH rehash answers came in a row before it, it answers rehash.
  - Otherwise it answers miss fault, and the count of consecutive rehash answers is cleared.
  - Any access answered with something other than rehash also clears that count.
- R8: A request is accepted on a rising edge where `req_valid_i` and `ready_o` are both high. `ready_o` is low in the following cycle. `rsp_valid_o` is high for exactly the one cycle after the second edge following acceptance. A request held while `ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Operation code |
| req_line_i | input | LINE_W | Hashed physical line index |
| req_ref_i | input | REF_W | Object reference of the virtual tag |
| req_idx_i | input | IDX_W | Line index within the object |
| ready_o | output | 1 | Block can accept a request this cycle |
| rsp_valid_o | output | 1 | Response present |
| rsp_kind_o | output | 3 | Response code |
| rsp_count_o | output | 2 | Line count before the request |

## Verification
The bench builds the block with LINE_W=4, REF_W=8, IDX_W=8 and MAX_REHASH=2. With 16 lines, the init sweep is short enough to time edge by edge, and both the first and the last line are reachable. A limit of two means a miss fault appears on the third consecutive mismatch. The rehash counter's clearing by an intervening tag hit then becomes visible within a few requests. The tags differ in only the reference or only the index, so each half of the compare is exercised.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  typedef enum logic [1:0] {
    CNT_ZERO    = 2'b00,
    CNT_ONE     = 2'b01,
    CNT_MANY    = 2'b10,
    CNT_UNKNOWN = 2'b11
  } cnt_e;

  typedef enum logic [1:0] {
    OP_ACCESS  = 2'b00,
    OP_ALLOC   = 2'b01,
    OP_DEALLOC = 2'b10,
    OP_RSVD    = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    RSP_DIRECT  = 3'd0,
    RSP_INVALID = 3'd1,
    RSP_TAG_HIT = 3'd2,
    RSP_REHASH  = 3'd3,
    RSP_FAULT   = 3'd4,
    RSP_UPDATED = 3'd5
  } rsp_e;
endpackage

// File: rtl/lhc_sram.sv
module lhc_sram #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lhc_init_sweep.sv
module lhc_init_sweep #(
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              busy_o,
  output logic [LINE_W-1:0] addr_o
);
  logic [LINE_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '1) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cnt_q;

  // sweep runs once per reset
  assert_sweep_once_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !busy_q);
endmodule

// File: rtl/lhc_resolve.sv
module lhc_resolve
  import lhc_pkg::*;
(
  input  op_e  op_i,
  input  cnt_e cnt_i,
  input  logic tag_match_i,
  input  logic at_limit_i,
  output cnt_e nxt_cnt_o,
  output logic cnt_we_o,
  output logic tag_we_o,
  output rsp_e kind_o
);
  always_comb begin
    nxt_cnt_o = cnt_i;
    cnt_we_o  = 1'b0;
    tag_we_o  = 1'b0;
    kind_o    = RSP_UPDATED;
    unique case (op_i)
      OP_ALLOC: begin
        cnt_we_o = 1'b1;
        if (cnt_i == CNT_ZERO) begin
          nxt_cnt_o = CNT_ONE;
          tag_we_o  = 1'b1;
        end else begin
          nxt_cnt_o = CNT_MANY;
        end
      end
      OP_DEALLOC: begin
        cnt_we_o = 1'b1;
        if (cnt_i == CNT_ONE)       nxt_cnt_o = CNT_ZERO;
        else if (cnt_i == CNT_MANY) nxt_cnt_o = CNT_UNKNOWN;
      end
      default: begin
        unique case (cnt_i)
          CNT_ZERO: kind_o = RSP_INVALID;
          CNT_ONE:  kind_o = RSP_DIRECT;
          default:  kind_o = tag_match_i ? RSP_TAG_HIT
                           : (at_limit_i ? RSP_FAULT : RSP_REHASH);
        endcase
      end
    endcase
  end
endmodule

// File: rtl/line_alloc_ctrl.sv
module line_alloc_ctrl
  import lhc_pkg::*;
#(
  parameter int LINE_W     = 8,
  parameter int REF_W      = 16,
  parameter int IDX_W      = 12,
  parameter int MAX_REHASH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [REF_W-1:0]  req_ref_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_kind_o,
  output logic [1:0]        rsp_count_o
);
  localparam int NLINES = 1 << LINE_W;
  localparam int TAG_W  = REF_W + IDX_W;
  localparam int RW     = (MAX_REHASH < 1) ? 1 : $clog2(MAX_REHASH + 1);
  localparam logic [RW-1:0] RETRY_MAX = RW'(MAX_REHASH);

  logic              sweep_busy;
  logic [LINE_W-1:0] sweep_addr;
  logic              req_fire;

  logic              s1_valid_q;
  op_e               s1_op_q;
  logic [LINE_W-1:0] s1_line_q;
  logic [TAG_W-1:0]  s1_tag_q;

  logic [1:0]        cnt_rd;
  logic [TAG_W-1:0]  tag_rd;
  logic              state_we;
  logic [LINE_W-1:0] state_waddr;
  logic [1:0]        state_wdata;

  cnt_e              nxt_cnt;
  logic              cnt_we, tag_we;
  rsp_e              kind;
  logic [RW-1:0]     retry_q;

  logic              rsp_valid_q;
  logic [2:0]        rsp_kind_q;
  logic [1:0]        rsp_cnt_q;

  lhc_init_sweep #(.LINE_W(LINE_W)) u_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (sweep_busy),
    .addr_o (sweep_addr)
  );

  assign ready_o  = !sweep_busy && !s1_valid_q;
  assign req_fire = req_valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_op_q    <= OP_ACCESS;
      s1_line_q  <= '0;
      s1_tag_q   <= '0;
    end else begin
      s1_valid_q <= req_fire;
      if (req_fire) begin
        s1_op_q   <= op_e'(req_op_i);
        s1_line_q <= req_line_i;
        s1_tag_q  <= {req_ref_i, req_idx_i};
      end
    end
  end

  // count and tag are read in the same cycle
  assign state_we    = sweep_busy || (s1_valid_q && cnt_we);
  assign state_waddr = sweep_busy ? sweep_addr : s1_line_q;
  assign state_wdata = sweep_busy ? CNT_ZERO : nxt_cnt;

  lhc_sram #(.WIDTH(2), .DEPTH(NLINES)) u_state_ram (
    .clk_i   (clk_i),
    .we_i    (state_we),
    .waddr_i (state_waddr),
    .wdata_i (state_wdata),
    .re_i    (req_fire),
    .raddr_i (req_line_i),
    .rdata_o (cnt_rd)
  );

  lhc_sram #(.WIDTH(TAG_W), .DEPTH(NLINES)) u_tag_ram (
    .clk_i   (clk_i),
    .we_i    (s1_valid_q && tag_we),
    .waddr_i (s1_line_q),
    .wdata_i (s1_tag_q),
    .re_i    (req_fire),
    .raddr_i (req_line_i),
    .rdata_o (tag_rd)
  );

  lhc_resolve u_resolve (
    .op_i        (s1_op_q),
    .cnt_i       (cnt_e'(cnt_rd)),
    .tag_match_i (tag_rd == s1_tag_q),
    .at_limit_i  (retry_q == RETRY_MAX),
    .nxt_cnt_o   (nxt_cnt),
    .cnt_we_o    (cnt_we),
    .tag_we_o    (tag_we),
    .kind_o      (kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= '0;
      rsp_cnt_q   <= '0;
    end else begin
      rsp_valid_q <= s1_valid_q;
      if (s1_valid_q) begin
        rsp_kind_q <= kind;
        rsp_cnt_q  <= cnt_rd;
        if (s1_op_q == OP_ACCESS || s1_op_q == OP_RSVD)
          retry_q <= (kind == RSP_REHASH) ? retry_q + 1'b1 : '0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_kind_o  = rsp_kind_q;
  assign rsp_count_o = rsp_cnt_q;

  assert_init_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_busy |-> (!ready_o && !rsp_valid_o));
  assert_access_keeps_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && (s1_op_q == OP_ACCESS || s1_op_q == OP_RSVD)) |-> !state_we);
  assert_retry_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= RETRY_MAX);
  assert_fault_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == RSP_FAULT) |-> (retry_q == '0));
  assert_issue_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire |=> !ready_o);
  assert_rsp_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |=> rsp_valid_o);
  assert_rsp_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(s1_valid_q));
endmodule

// File: tb/line_alloc_ctrl_tb.sv
`timescale 1ns/1ps
module line_alloc_ctrl_tb;
  localparam int LINE_W = 4;
  localparam int REF_W  = 8;
  localparam int IDX_W  = 8;
  localparam int MAXR   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [LINE_W-1:0] req_line = '0;
  logic [REF_W-1:0] req_ref = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic ready, rsp_valid;
  logic [2:0] rsp_kind;
  logic [1:0] rsp_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_alloc_ctrl #(.LINE_W(LINE_W), .REF_W(REF_W), .IDX_W(IDX_W), .MAX_REHASH(MAXR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_line_i(req_line), .req_ref_i(req_ref), .req_idx_i(req_idx),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_count_o(rsp_count)
  );

  // ops: 0 access, 1 alloc, 2 dealloc, 3 reserved(access)
  // kinds: 0 direct, 1 invalid, 2 tag hit, 3 rehash, 4 fault, 5 updated
  // counts: 0 zero, 1 one, 2 many, 3 unknown
  // tags: 0 A, 1 B (index differs), 2 C (reference differs), 3 D
  // entry: {op, line, tag, kind, prior count, requirement}
  localparam int NV = 34;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 4'd3,  2'd0, 3'd1, 2'd0, 4'd5},  // R5 zero -> invalid
    {2'd1, 4'd3,  2'd0, 3'd5, 2'd0, 4'd3},  // R3 zero -> one
    {2'd0, 4'd3,  2'd1, 3'd0, 2'd1, 4'd5},  // R5 one, tag ignored
    {2'd1, 4'd3,  2'd1, 3'd5, 2'd1, 4'd3},  // R3 one -> many
    {2'd1, 4'd3,  2'd1, 3'd5, 2'd2, 4'd3},  // R3 saturate
    {2'd1, 4'd3,  2'd1, 3'd5, 2'd2, 4'd3},  // R3 saturate
    {2'd0, 4'd3,  2'd0, 3'd2, 2'd2, 4'd6},  // R6 tag kept from first alloc
    {2'd0, 4'd3,  2'd1, 3'd3, 2'd2, 4'd7},  // R7 rehash 1
    {2'd0, 4'd3,  2'd1, 3'd3, 2'd2, 4'd7},  // R7 rehash 2
    {2'd0, 4'd3,  2'd1, 3'd4, 2'd2, 4'd7},  // R7 limit -> fault
    {2'd0, 4'd3,  2'd1, 3'd3, 2'd2, 4'd7},  // R7 cleared by fault
    {2'd0, 4'd3,  2'd0, 3'd2, 2'd2, 4'd7},  // R7 hit clears run
    {2'd0, 4'd3,  2'd1, 3'd3, 2'd2, 4'd7},
    {2'd0, 4'd3,  2'd1, 3'd3, 2'd2, 4'd7},  // R7 still rehash: run was cleared
    {2'd0, 4'd3,  2'd0, 3'd2, 2'd2, 4'd6},
    {2'd2, 4'd3,  2'd0, 3'd5, 2'd2, 4'd4},  // R4 many -> unknown
    {2'd0, 4'd3,  2'd0, 3'd2, 2'd3, 4'd6},  // R6 unknown + match
    {2'd0, 4'd3,  2'd2, 3'd3, 2'd3, 4'd7},  // R7 unknown + mismatch
    {2'd0, 4'd3,  2'd0, 3'd2, 2'd3, 4'd6},
    {2'd2, 4'd3,  2'd0, 3'd5, 2'd3, 4'd4},  // R4 unknown stays
    {2'd1, 4'd3,  2'd0, 3'd5, 2'd3, 4'd3},  // R3 unknown -> many
    {2'd0, 4'd3,  2'd0, 3'd2, 2'd2, 4'd3},
    {2'd1, 4'd5,  2'd2, 3'd5, 2'd0, 4'd3},
    {2'd0, 4'd5,  2'd0, 3'd0, 2'd1, 4'd5},  // R5 direct with foreign tag
    {2'd2, 4'd5,  2'd2, 3'd5, 2'd1, 4'd4},  // R4 one -> zero
    {2'd0, 4'd5,  2'd2, 3'd1, 2'd0, 4'd4},
    {2'd2, 4'd5,  2'd2, 3'd5, 2'd0, 4'd4},  // R4 zero stays
    {2'd0, 4'd5,  2'd2, 3'd1, 2'd0, 4'd4},
    {2'd1, 4'd5,  2'd3, 3'd5, 2'd0, 4'd3},  // R3 tag rewritten from zero
    {2'd1, 4'd5,  2'd3, 3'd5, 2'd1, 4'd3},
    {2'd0, 4'd5,  2'd3, 3'd2, 2'd2, 4'd3},
    {2'd0, 4'd15, 2'd0, 3'd1, 2'd0, 4'd1},  // R1 last line cleared
    {2'd0, 4'd0,  2'd0, 3'd1, 2'd0, 4'd1},  // R1 alloc during init ignored
    {2'd3, 4'd3,  2'd0, 3'd2, 2'd2, 4'd2}   // R2 reserved op acts as access
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_tag(input logic [1:0] ts);
    case (ts)
      2'd0: begin req_ref = 8'h11; req_idx = 8'h22; end
      2'd1: begin req_ref = 8'h11; req_idx = 8'h23; end
      2'd2: begin req_ref = 8'h12; req_idx = 8'h22; end
      default: begin req_ref = 8'h5a; req_idx = 8'ha5; end
    endcase
  endtask

  // called at a negedge; returns at the negedge where the response is visible
  task automatic do_req(input logic [1:0] op, input logic [LINE_W-1:0] line,
                        input logic [1:0] ts, input bit hold,
                        output logic [2:0] kind, output logic [1:0] cnt);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_line = line; set_tag(ts);
    @(posedge clk); @(negedge clk);
    if (hold) begin
      // R8 request held while not ready: change it, must be ignored
      req_op = 2'd1; req_line = 4'd7;
    end else req_valid = 1'b0;
    chk(ready == 1'b0, "R8 ready low after accept", ready, 0);
    chk(rsp_valid == 1'b0, "R8 no early response", rsp_valid, 0);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R8 response two edges after accept", rsp_valid, 1);
    kind = rsp_kind; cnt = rsp_count;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] k;
    logic [1:0] c;
    int lows;
    // R1 reset state, with an alloc on line 0 held through init
    req_valid = 1'b1; req_op = 2'd1; req_line = 4'd0; set_tag(2'd0);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready low in reset", ready, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid low in reset", rsp_valid, 0);
    rst_n = 1'b1;
    lows = 0;
    for (int e = 1; e <= 16; e++) begin
      @(negedge clk);
      if (e < 16 && !ready) lows++;
      if (e < 16 && rsp_valid) chk(1'b0, "R1 response during init", 1, 0);
      if (e == 16) begin
        req_valid = 1'b0;
        chk(ready == 1'b1, "R1 ready after 16 edges", ready, 1);
      end
    end
    chk(lows == 15, "R1 ready low during sweep", lows, 15);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] e;
      e = VEC[i];
      do_req(e[16:15], e[14:11], e[10:9], 1'b0, k, c);
      chk(k == e[8:6], $sformatf("R%0d kind vec %0d", e[3:0], i), k, e[8:6]);
      chk(c == e[5:4], $sformatf("R%0d count vec %0d", e[3:0], i), c, e[5:4]);
    end

    // R8 held request ignored: line 7 must still be zero
    do_req(2'd0, 4'd3, 2'd0, 1'b1, k, c);
    chk(k == 3'd2, "R8 held-request access kind", k, 2);
    do_req(2'd0, 4'd7, 2'd0, 1'b0, k, c);
    chk(k == 3'd1, "R8 held request not taken kind", k, 1);
    chk(c == 2'd0, "R8 held request not taken count", c, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 response lasts one cycle", rsp_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule